// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Unit

This block contains four counters behind a small register interface. Three of them are reloading countdown channels. Channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide. Each reloading channel decrements on its selected count strobe, reloads from its load register when it passes zero (or wraps to all ones when reload is off), and raises a sticky interrupt. The fourth counter is a 40-bit free-running up-counter. It runs on the fast strobe, has no interrupt, and is switched on by one bit in its upper register.

Count rates come from two single-cycle enables, `slow_tick` and `fast_tick`, which are synchronous to `clk`. Software sets a channel's mode and load value while the channel is stopped, then sets the enable bit to start it. Each reloading channel is a two-state machine. It moves from RL_HALT to RL_RUN (transition *start*) on a control write with the enable bit set, and from RL_RUN to RL_HALT (transition *stop*) on a control write with it clear. The free-running counter moves from FR_STOP to FR_RUN (transition *arm*) on an upper-register write with bit 8 set, and back to FR_STOP (transition *disarm*) on such a write with bit 8 clear.

Top module: `cdt_unit`

## Requirements
- R1: After reset every readable register returns zero, all channels are in RL_HALT, the free counter is in FR_STOP, and `irq` is 0.
- R2: A running channel decrements by one on each cycle in which its selected strobe is high. A halted channel holds its count under any strobe.
- R3: With reload on and a load value of N-1, a running channel underflows on every Nth selected tick and restarts its count from the load value.
- R4: With reload off, an underflow sets the count to all ones of the channel width, and the channel keeps counting down from there.
- R5: An underflow sets that channel's `irq` bit on the next edge, and the bit stays set. A write of any data to the channel's clear register drops it. If a clear and an underflow fall in the same cycle, the bit stays set.
- R6: A load write to a halted channel also sets its count to the new value. A load write to a running channel changes only the load register.
- R7: Control register bits: bit 7 = enable, bit 6 = reload, bit 3 = strobe select (1 = `slow_tick`, 0 = `fast_tick`). The control register reads back exactly these three bits.
- R8: Channels 0 and 1 keep 16 bits and channel 2 keeps 32 bits. Load bits above a channel's width are dropped and read as zero.
- R9: The free counter keeps 40 bits and adds one on each `fast_tick` while in FR_RUN. It holds its value in FR_STOP. Its low register returns bits 31:0. Its high register returns bits 39:32 in bits 7:0 and the run flag in bit 8.
- R10: Address map (byte addresses, word aligned): channel c sits at base c*0x20, with load at +0x0, count at +0x4, control at +0x8 and clear at +0xC. Free counter low is at 0x60 and high is at 0x64.
- R11: Reads are combinational from the current state. Unmapped addresses and unused bits read zero. Writes to count registers, to the free counter low register and to unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Single-cycle slow count enable |
| fast_tick | input | 1 | Single-cycle fast count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 3 | Sticky underflow interrupt, one bit per reloading channel |

## Verification
Two events can land in the same cycle. One is an underflow on a selected tick, which sets the interrupt. The other is a clear-register write, which drops it. The bench brings channel 0 to a count of zero and then drives a slow tick together with a clear write. It expects `irq[0]` to stay high and the count to reload. A second pair is a load write to a running channel in the same cycle as a tick; here the count must follow the tick and ignore the write. Both cases also come up many times in the random phase. There, a behavioural reference model is compared against `irq` and one rotating register address on every clock.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int NUM_RL  = 3;

    // register index inside a channel window (address bits 3:2)
    localparam logic [1:0] REG_LOAD  = 2'd0;
    localparam logic [1:0] REG_COUNT = 2'd1;
    localparam logic [1:0] REG_CTRL  = 2'd2;
    localparam logic [1:0] REG_CLEAR = 2'd3;

    // window index (address bits 6:5) used by the free counter
    localparam logic [1:0] FR_IDX    = 2'd3;
    localparam logic [1:0] FR_LOW    = 2'd0;
    localparam logic [1:0] FR_HIGH   = 2'd1;

    // control bit positions
    localparam int CTL_EN    = 7;
    localparam int CTL_PER   = 6;
    localparam int CTL_SLOW  = 3;
    localparam int FR_RUN_BIT = 8;

    typedef struct packed {
        logic en;
        logic per;
        logic slow;
    } rl_ctl_t;

    typedef enum logic {
        RL_HALT = 1'b0,
        RL_RUN  = 1'b1
    } rl_state_e;

    typedef enum logic {
        FR_STOP = 1'b0,
        FR_RUN  = 1'b1
    } fr_state_e;

    function automatic int rl_width(input int idx, input int narrow_w, input int wide_w);
        return (idx == NUM_RL - 1) ? wide_w : narrow_w;
    endfunction

endpackage

// File: rtl/cdt_reload_timer.sv
module cdt_reload_timer
    import cdt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         slow_tick,
    input  logic         fast_tick,
    input  logic         ld_wr,
    input  logic [W-1:0] ld_data,
    input  logic         ctl_wr,
    input  rl_ctl_t      ctl_data,
    input  logic         clr_wr,
    output logic [W-1:0] load_q,
    output logic [W-1:0] cnt_q,
    output rl_ctl_t      ctl_q,
    output logic         irq,
    output logic         uf,
    output logic         running
);

    rl_state_e state_q, state_d;
    logic      per_q;
    logic      slow_q;
    logic      tick;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RL_HALT;
        else        state_q <= state_d;
    end

    // next state: start / stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RL_HALT: if (ctl_wr &&  ctl_data.en) state_d = RL_RUN;
            RL_RUN:  if (ctl_wr && !ctl_data.en) state_d = RL_HALT;
        endcase
    end

    assign running = (state_q == RL_RUN);
    assign tick    = running && (slow_q ? slow_tick : fast_tick);
    assign uf      = tick && (cnt_q == '0);
    assign ctl_q   = '{en: running, per: per_q, slow: slow_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q  <= 1'b0;
            slow_q <= 1'b0;
        end else if (ctl_wr) begin
            per_q  <= ctl_data.per;
            slow_q <= ctl_data.slow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     load_q <= '0;
        else if (ld_wr) load_q <= ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (uf) cnt_q <= per_q ? load_q : '1;
            else    cnt_q <= cnt_q - 1'b1;
        end else if (ld_wr && !running) begin
            cnt_q <= ld_data;
        end
    end

    // output process: sticky interrupt, underflow has priority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      irq <= 1'b0;
        else if (uf)     irq <= 1'b1;
        else if (clr_wr) irq <= 1'b0;
    end

endmodule

// File: rtl/cdt_freerun.sv
module cdt_freerun
    import cdt_pkg::*;
#(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fast_tick,
    input  logic         hi_wr,
    input  logic         hi_run,
    output logic [W-1:0] cnt_q,
    output logic         running
);

    fr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_STOP;
        else        state_q <= state_d;
    end

    // arm / disarm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_STOP: if (hi_wr &&  hi_run) state_d = FR_RUN;
            FR_RUN:  if (hi_wr && !hi_run) state_d = FR_STOP;
        endcase
    end

    assign running = (state_q == FR_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (running && fast_tick)  cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/cdt_unit.sv
module cdt_unit
    import cdt_pkg::*;
#(
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    parameter int FREE_W   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_RL-1:0] irq
);

    localparam int HI_W = FREE_W - DATA_W;

    logic                           wr_ok;
    logic [1:0]                     wr_idx;
    logic [1:0]                     wr_reg;
    logic                           rd_ok;
    logic [1:0]                     rd_idx;
    logic [1:0]                     rd_reg;

    logic [NUM_RL-1:0]              uf_vec;
    logic [NUM_RL-1:0]              run_vec;
    logic [NUM_RL-1:0]              ld_wr_vec;
    logic [NUM_RL-1:0]              ctl_wr_vec;
    logic [NUM_RL-1:0]              clr_wr_vec;
    logic [NUM_RL-1:0][DATA_W-1:0]  load_pk;
    logic [NUM_RL-1:0][DATA_W-1:0]  cnt_pk;
    logic [NUM_RL-1:0][2:0]         ctl_pk;

    rl_ctl_t                        ctl_wdata;
    logic                           fr_hi_wr;
    logic [FREE_W-1:0]              fr_cnt;
    logic                           fr_run;

    assign wr_ok  = wr_en && !wr_addr[7] && !wr_addr[4] && (wr_addr[1:0] == 2'b00);
    assign wr_idx = wr_addr[6:5];
    assign wr_reg = wr_addr[3:2];
    assign ctl_wdata = '{en: wr_data[CTL_EN], per: wr_data[CTL_PER], slow: wr_data[CTL_SLOW]};
    assign fr_hi_wr  = wr_ok && (wr_idx == FR_IDX) && (wr_reg == FR_HIGH);

    for (genvar g = 0; g < NUM_RL; g++) begin : g_rl
        localparam int CW = rl_width(g, NARROW_W, WIDE_W);
        logic [CW-1:0] load_q;
        logic [CW-1:0] cnt_q;
        rl_ctl_t       ctl_q;
        logic          hit;

        assign hit            = wr_ok && (wr_idx == 2'(g));
        assign ld_wr_vec[g]   = hit && (wr_reg == REG_LOAD);
        assign ctl_wr_vec[g]  = hit && (wr_reg == REG_CTRL);
        assign clr_wr_vec[g]  = hit && (wr_reg == REG_CLEAR);

        cdt_reload_timer #(.W(CW)) u_rl (
            .clk       (clk),
            .rst_n     (rst_n),
            .slow_tick (slow_tick),
            .fast_tick (fast_tick),
            .ld_wr     (ld_wr_vec[g]),
            .ld_data   (wr_data[CW-1:0]),
            .ctl_wr    (ctl_wr_vec[g]),
            .ctl_data  (ctl_wdata),
            .clr_wr    (clr_wr_vec[g]),
            .load_q    (load_q),
            .cnt_q     (cnt_q),
            .ctl_q     (ctl_q),
            .irq       (irq[g]),
            .uf        (uf_vec[g]),
            .running   (run_vec[g])
        );

        assign load_pk[g] = DATA_W'(load_q);
        assign cnt_pk[g]  = DATA_W'(cnt_q);
        assign ctl_pk[g]  = ctl_q;
    end

    cdt_freerun #(.W(FREE_W)) u_fr (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_tick (fast_tick),
        .hi_wr     (fr_hi_wr),
        .hi_run    (wr_data[FR_RUN_BIT]),
        .cnt_q     (fr_cnt),
        .running   (fr_run)
    );

    assign rd_ok  = !rd_addr[7] && !rd_addr[4] && (rd_addr[1:0] == 2'b00);
    assign rd_idx = rd_addr[6:5];
    assign rd_reg = rd_addr[3:2];

    always_comb begin
        rd_data = '0;
        if (rd_ok) begin
            if (rd_idx == FR_IDX) begin
                if (rd_reg == FR_LOW) begin
                    rd_data = fr_cnt[DATA_W-1:0];
                end else if (rd_reg == FR_HIGH) begin
                    rd_data[HI_W-1:0]  = fr_cnt[FREE_W-1:DATA_W];
                    rd_data[FR_RUN_BIT] = fr_run;
                end
            end else begin
                unique case (rd_reg)
                    REG_LOAD:  rd_data = load_pk[rd_idx];
                    REG_COUNT: rd_data = cnt_pk[rd_idx];
                    REG_CTRL: begin
                        rd_data[CTL_EN]   = ctl_pk[rd_idx][2];
                        rd_data[CTL_PER]  = ctl_pk[rd_idx][1];
                        rd_data[CTL_SLOW] = ctl_pk[rd_idx][0];
                    end
                    REG_CLEAR: rd_data = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/cdt_unit_chk.sv
module cdt_unit_chk
    import cdt_pkg::*;
#(
    parameter int FREE_W = 40
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          fast_tick,
    input logic [NUM_RL-1:0]             irq,
    input logic [NUM_RL-1:0]             uf_vec,
    input logic [NUM_RL-1:0]             run_vec,
    input logic [NUM_RL-1:0]             ld_wr_vec,
    input logic [NUM_RL-1:0]             clr_wr_vec,
    input logic [NUM_RL-1:0][DATA_W-1:0] cnt_pk,
    input logic [FREE_W-1:0]             fr_cnt,
    input logic                          fr_run
);

    for (genvar g = 0; g < NUM_RL; g++) begin : g_chk
        p_uf_sets_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
            uf_vec[g] |=> irq[g]);

        p_clear_drops_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr_vec[g] && !uf_vec[g]) |=> !irq[g]);

        p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[g]) |-> $past(uf_vec[g]));

        p_halt_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_vec[g] && !ld_wr_vec[g]) |=> $stable(cnt_pk[g]));

        p_uf_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
            uf_vec[g] |-> (run_vec[g] && cnt_pk[g] == '0));
    end

    p_free_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fr_run |=> $stable(fr_cnt));

    p_free_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_run && fast_tick) |=> (fr_cnt == $past(fr_cnt) + 1'b1));

endmodule

bind cdt_unit cdt_unit_chk #(.FREE_W(FREE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fast_tick  (fast_tick),
    .irq        (irq),
    .uf_vec     (uf_vec),
    .run_vec    (run_vec),
    .ld_wr_vec  (ld_wr_vec),
    .clr_wr_vec (clr_wr_vec),
    .cnt_pk     (cnt_pk),
    .fr_cnt     (fr_cnt),
    .fr_run     (fr_run)
);

// File: tb/cdt_unit_tb.sv
module cdt_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        fast_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [2:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit cmp_on = 0;
    int rot = 0;

    // reference model state
    int unsigned     m_ld [3];
    int unsigned     m_cnt[3];
    bit [7:0]        m_ctl[3];
    bit              m_irq[3];
    longint unsigned m_fr;
    bit              m_fr_run;

    logic [7:0] rot_list [12] = '{8'h00, 8'h04, 8'h08, 8'h20, 8'h24, 8'h28,
                                  8'h40, 8'h44, 8'h48, 8'h60, 8'h64, 8'h70};

    always #5 clk = ~clk;

    cdt_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .fast_tick (fast_tick),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    function automatic int unsigned wmask(input int i);
        return (i == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int i;
        if (a[7] || a[4] || a[1:0] != 2'b00) return '0;
        i = int'(a[6:5]);
        if (i == 3) begin
            if (a[3:2] == 2'd0) return m_fr[31:0];
            if (a[3:2] == 2'd1) return {23'd0, m_fr_run, m_fr[39:32]};
            return '0;
        end
        case (a[3:2])
            2'd0:    return m_ld[i];
            2'd1:    return m_cnt[i];
            2'd2:    return {24'd0, m_ctl[i]};
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] a);
        if (a == 8'h60 || a == 8'h64) return "R9";
        if (a[7] || a[4] || a[6:5] == 2'd3) return "R11";
        case (a[3:2])
            2'd0:    return "R6";
            2'd1:    return "R2";
            2'd2:    return "R7";
            default: return "R11";
        endcase
    endfunction

    // behavioural model, updated on every clock edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_ld[i] = 0; m_cnt[i] = 0; m_ctl[i] = 0; m_irq[i] = 0;
            end
            m_fr = 0; m_fr_run = 0;
        end else begin
            bit wok;
            wok = wr_en && !wr_addr[7] && !wr_addr[4] && wr_addr[1:0] == 2'b00;
            for (int i = 0; i < 3; i++) begin
                bit run, tk, under, hit;
                int unsigned nc;
                run = m_ctl[i][7];
                tk = run && (m_ctl[i][3] ? slow_tick : fast_tick);
                under = 0;
                nc = m_cnt[i];
                if (tk) begin
                    if (m_cnt[i] == 0) begin
                        under = 1;
                        nc = m_ctl[i][6] ? m_ld[i] : wmask(i);
                    end else begin
                        nc = m_cnt[i] - 1;
                    end
                end
                hit = wok && int'(wr_addr[6:5]) == i;
                if (hit && wr_addr[3:2] == 2'd0) begin
                    m_ld[i] = wr_data & wmask(i);
                    if (!run) nc = wr_data & wmask(i);
                end
                if (hit && wr_addr[3:2] == 2'd2) m_ctl[i] = wr_data[7:0] & 8'hC8;
                if (under) m_irq[i] = 1;
                else if (hit && wr_addr[3:2] == 2'd3) m_irq[i] = 0;
                m_cnt[i] = nc;
            end
            if (m_fr_run && fast_tick) m_fr = (m_fr + 1) & 64'h00FF_FFFF_FFFF;
            if (wok && wr_addr == 8'h64) m_fr_run = wr_data[8];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R5", {29'd0, irq}, {29'd0, m_irq[2], m_irq[1], m_irq[0]});
            chk(req_of(rd_addr), rd_data, m_read(rd_addr));
        end
    end

    task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d,
                       input bit s, input bit f);
        @(negedge clk);
        #1;
        wr_en = we; wr_addr = a; wr_data = d;
        slow_tick = s; fast_tick = f;
        rd_addr = rot_list[rot % 12];
        rot++;
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic idle();
        cyc(1'b0, 8'h00, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic stick(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic ftick(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, 32'h0, 1'b0, 1'b1);
    endtask

    task automatic peek(input logic [7:0] a, input logic [31:0] exp, input string req);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        idle();

        // R1: reset state
        foreach (rot_list[k]) peek(rot_list[k], 32'h0, "R1");
        chk("R1", {29'd0, irq}, 32'h0);

        // R3: channel 0, reload with load 4 -> underflow every 5 slow ticks
        wreg(8'h08, 32'h48);
        wreg(8'h00, 32'h4);
        wreg(8'h08, 32'hC8);
        idle();
        peek(8'h04, 32'h4, "R6");
        stick(4);
        idle();
        peek(8'h04, 32'h0, "R3");
        chk("R3", {31'd0, irq[0]}, 32'h0);
        stick(1);
        idle();
        peek(8'h04, 32'h4, "R3");
        chk("R3", {31'd0, irq[0]}, 32'h1);
        // R5: clear drops the interrupt
        wreg(8'h0C, 32'h0);
        idle();
        chk("R5", {31'd0, irq[0]}, 32'h0);
        // R5: clear and underflow in the same cycle, underflow wins
        stick(4);
        cyc(1'b1, 8'h0C, 32'h0, 1'b1, 1'b0);
        idle();
        chk("R5", {31'd0, irq[0]}, 32'h1);
        peek(8'h04, 32'h4, "R3");
        wreg(8'h0C, 32'hDEAD);
        wreg(8'h08, 32'h48);
        idle();
        chk("R5", {31'd0, irq[0]}, 32'h0);

        // R4/R8: channel 1, no reload, 16-bit wrap
        wreg(8'h28, 32'h08);
        wreg(8'h20, 32'hABCD_0001);
        idle();
        peek(8'h20, 32'h0001, "R8");
        peek(8'h24, 32'h0001, "R6");
        wreg(8'h28, 32'h88);
        stick(2);
        idle();
        peek(8'h24, 32'hFFFF, "R4");
        chk("R4", {31'd0, irq[1]}, 32'h1);
        stick(1);
        idle();
        peek(8'h24, 32'hFFFE, "R4");
        peek(8'h28, 32'h88, "R7");
        wreg(8'h28, 32'hFF);
        idle();
        peek(8'h28, 32'hC8, "R11");
        wreg(8'h28, 32'h08);
        wreg(8'h2C, 32'h0);

        // R7/R2/R6: channel 2 on the fast strobe
        wreg(8'h48, 32'h00);
        wreg(8'h40, 32'h1234_5678);
        wreg(8'h48, 32'h80);
        idle();
        peek(8'h44, 32'h1234_5678, "R10");
        stick(3);
        idle();
        peek(8'h44, 32'h1234_5678, "R7");
        ftick(2);
        idle();
        peek(8'h44, 32'h1234_5676, "R2");
        cyc(1'b1, 8'h40, 32'h10, 1'b0, 1'b1);
        idle();
        peek(8'h44, 32'h1234_5675, "R6");
        peek(8'h40, 32'h10, "R6");
        wreg(8'h48, 32'h00);
        ftick(3);
        idle();
        peek(8'h44, 32'h1234_5675, "R2");
        wreg(8'h44, 32'h5);
        idle();
        peek(8'h44, 32'h1234_5675, "R11");
        // R8: 32-bit wrap
        wreg(8'h40, 32'h0);
        wreg(8'h48, 32'h80);
        ftick(1);
        idle();
        peek(8'h44, 32'hFFFF_FFFF, "R8");
        chk("R5", {31'd0, irq[2]}, 32'h1);
        wreg(8'h48, 32'h00);
        wreg(8'h4C, 32'h0);

        // R9: free counter
        ftick(2);
        idle();
        peek(8'h60, 32'h0, "R9");
        wreg(8'h60, 32'h77);
        wreg(8'h64, 32'h100);
        ftick(3);
        stick(2);
        idle();
        peek(8'h60, 32'h3, "R9");
        peek(8'h64, 32'h100, "R9");
        peek(8'h6C, 32'h0, "R11");
        peek(8'h70, 32'h0, "R11");
        peek(8'h05, 32'h0, "R11");

        // random phase, checked against the model every clock
        for (int n = 0; n < 600; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            bit          we;
            we = ($urandom_range(0, 3) == 0);
            a  = rot_list[$urandom_range(0, 11)];
            if ($urandom_range(0, 3) == 0) a = a | 8'h0C;
            d  = $urandom;
            if (a[3:2] == 2'd0) d = $urandom_range(0, 7);
            cyc(we, a, d, ($urandom_range(0, 2) == 0), ($urandom_range(0, 1) == 0));
        end
        idle();
        idle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule